// File: doc/BRIEF.md
# Eight-Channel Mode-Driven Transfer Engine

This block moves one data item per trigger on behalf of eight independent channels. Each channel holds a source address, a destination address, a transfer count and a 5-bit mode word. When a channel's trigger is taken, the engine reads one item from the source address, writes it to the destination address, and then steps the addresses as the mode word asks. Every address step happens after the access, so each access uses the address value from before the step. The engine then lowers the channel's count by one. When that count reaches zero, it pulses the channel's terminal-count line.

Software or a controller loads the channel registers through a simple write port. The memory side is a request/acknowledge bus that allows only one access in flight. Triggers from several channels are queued as pending, and the lowest-numbered pending channel is served first. A counting mode moves no data at all: it advances the source register by one and lowers the count. This lets a channel act as an event counter. A mode word the engine cannot carry out is refused: the channel's error flag is set and its registers stay as they were.

Top module: `dma_xfer_engine`

## Requirements
- R1: After a synchronous reset, busy, mem_req, tc_irq and err_flag are all low. Every channel's registers are zero.
- R2: In a data-moving transfer, the engine issues one read (mem_we=0) at the channel's source address and then one write (mem_we=1) at the channel's destination address. The write carries the data word that the read returned. mem_size carries mode bits [1:0], where 00 means 1 byte, 01 means 2 bytes and 10 means 4 bytes.
- R3: Mode bits [4:2] select the address step, applied after the transfer. The step is 1, 2 or 4 bytes, matching the size. The codes are: 000 destination goes up; 001 destination goes down; 010 source goes up; 011 source goes down; 100 both go up; 101 both go down.
- R4: Each transfer lowers the channel count by one. When the count becomes zero, tc_irq for that channel alone is high for exactly one cycle, in the first cycle after busy falls.
- R5: Mode 111 with size 00 (counting mode) makes no memory request. It adds one to the source register and lowers the count.
- R6: When every access is acknowledged in the cycle it is requested, busy stays high for 6 cycles in modes 100 and 101, and for 5 cycles in all other modes, counting mode included.
- R7: While mem_ack is low, mem_req, mem_we and mem_addr hold steady. Each such wait cycle lengthens the transfer by one cycle.
- R8: When several channels are pending, the lowest-numbered channel is served first. A trigger that arrives during a transfer is held and served later.
- R9: A size code of 11, or mode 111 with any size other than 00, sets that channel's err_flag bit. The trigger is then dropped: there is no transfer and no register change. Writing that channel's mode register clears the flag.
- R10: A trigger on a channel whose count is zero is dropped. There is no bus activity, no interrupt and no error.
- R11: Mode 110 moves data but leaves both addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | NUM_CH | Per-channel transfer trigger, one bit per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel selected for the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 mode |
| cfg_wdata | input | ADDR_W | Write data. The count uses the low CNT_W bits and the mode uses the low 5 bits |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access, 0 for a read access |
| mem_addr | output | ADDR_W | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid when mem_ack is high |
| mem_ack | input | 1 | Access completes in this cycle |
| tc_irq | output | NUM_CH | Terminal-count pulse, one bit per channel |
| err_flag | output | NUM_CH | Illegal-mode flag, one bit per channel |
| busy | output | 1 | A transfer is in progress |

## Verification
The assertions assume that the memory side eventually acknowledges every request. They also assume that the memory side never returns mem_ack while mem_req is low. The cycle-count property further assumes that no register write targets a channel while its own transfer is running. The testbench's memory model acknowledges after a programmable number of wait cycles, from zero to a small bound. The testbench loads channel registers only while the engine is idle, and illegal mode words reach the engine only in the cases that exercise the refusal path.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  // Address-update behaviour, taken from mode word bits [4:2]
  typedef enum logic [2:0] {
    MD_DST_INC  = 3'b000,
    MD_DST_DEC  = 3'b001,
    MD_SRC_INC  = 3'b010,
    MD_SRC_DEC  = 3'b011,
    MD_BOTH_INC = 3'b100,
    MD_BOTH_DEC = 3'b101,
    MD_FIXED    = 3'b110,
    MD_COUNT    = 3'b111
  } xfer_mode_e;

  // Register selector on the write port
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  // Sequencer states; each one takes one cycle unless it is waiting for an acknowledge
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WRITE,
    ST_STEP_A,
    ST_STEP_B,
    ST_DONE
  } seq_state_e;

  // A mode word is accepted unless its size is reserved, or it asks for counting with a nonzero size
  function automatic logic mode_word_ok(input logic [4:0] mw);
    logic size_bad;
    logic count_bad;
    size_bad  = (mw[1:0] == 2'b11);
    count_bad = (mw[4:2] == 3'b111) && (mw[1:0] != 2'b00);
    return !(size_bad || count_bad);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  // register write port
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  // update port from the sequencer
  input  logic [CH_W-1:0]   upd_ch,
  input  logic              upd_src_we,
  input  logic              upd_dst_we,
  input  logic              upd_cnt_we,
  input  logic [ADDR_W-1:0] upd_src,
  input  logic [ADDR_W-1:0] upd_dst,
  input  logic [CNT_W-1:0]  upd_cnt,
  // read port
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [4:0]        rd_mode
);
  import dma_xfer_pkg::*;

  logic [ADDR_W-1:0] src_r  [NUM_CH];
  logic [ADDR_W-1:0] dst_r  [NUM_CH];
  logic [CNT_W-1:0]  cnt_r  [NUM_CH];
  logic [4:0]        mode_r [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cfg_hit;
    logic upd_hit;
    assign cfg_hit = cfg_we && (cfg_ch == CH_W'(c));
    assign upd_hit = (upd_ch == CH_W'(c));

    // A write from the port takes precedence over the sequencer for this channel in that cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        src_r[c]  <= '0;
        dst_r[c]  <= '0;
        cnt_r[c]  <= '0;
        mode_r[c] <= '0;
      end else if (cfg_hit) begin
        unique case (reg_sel_e'(cfg_sel))
          SEL_SRC:  src_r[c]  <= cfg_wdata;
          SEL_DST:  dst_r[c]  <= cfg_wdata;
          SEL_CNT:  cnt_r[c]  <= cfg_wdata[CNT_W-1:0];
          SEL_MODE: mode_r[c] <= cfg_wdata[4:0];
          default:  ;
        endcase
      end else if (upd_hit) begin
        if (upd_src_we) src_r[c] <= upd_src;
        if (upd_dst_we) dst_r[c] <= upd_dst;
        if (upd_cnt_we) cnt_r[c] <= upd_cnt;
      end
    end
  end

  assign rd_src  = src_r[rd_ch];
  assign rd_dst  = dst_r[rd_ch];
  assign rd_cnt  = cnt_r[rd_ch];
  assign rd_mode = mode_r[rd_ch];

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] trig,
  input  logic              take,
  input  logic [CH_W-1:0]   take_ch,
  output logic              any_pend,
  output logic [CH_W-1:0]   grant_ch
);

  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] take_vec;

  always_comb begin
    take_vec = '0;
    if (take) take_vec[take_ch] = 1'b1;
  end

  // A new trigger on the bit being taken in the same cycle stays pending
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~take_vec) | trig;
  end

  // Scan from the top down so that the lowest pending index wins
  always_comb begin
    grant_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) grant_ch = CH_W'(i);
    end
  end

  assign any_pend = |pend_q;

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  // arbiter side
  input  logic              any_pend,
  input  logic [CH_W-1:0]   grant_ch,
  output logic              take,
  // register file side
  output logic [CH_W-1:0]   rd_ch,
  input  logic [ADDR_W-1:0] rd_src,
  input  logic [ADDR_W-1:0] rd_dst,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic [4:0]        rd_mode,
  output logic [CH_W-1:0]   upd_ch,
  output logic              upd_src_we,
  output logic              upd_dst_we,
  output logic              upd_cnt_we,
  output logic [ADDR_W-1:0] upd_src,
  output logic [ADDR_W-1:0] upd_dst,
  output logic [CNT_W-1:0]  upd_cnt,
  // memory side
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  // status
  input  logic [NUM_CH-1:0] err_clr,
  output logic [NUM_CH-1:0] tc_irq,
  output logic [NUM_CH-1:0] err_flag,
  output logic              busy
);
  import dma_xfer_pkg::*;

  seq_state_e        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [CNT_W-1:0]  cnt_q;
  xfer_mode_e        mode_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] data_q;
  logic [NUM_CH-1:0] tc_q;
  logic [NUM_CH-1:0] err_q;

  logic [ADDR_W-1:0] step;
  logic [NUM_CH-1:0] ch_vec;
  logic              is_count;
  logic              two_steps;
  logic              acc_done;

  assign step      = ADDR_W'(1) << size_q;
  assign is_count  = (mode_q == MD_COUNT);
  assign two_steps = (mode_q == MD_BOTH_INC) || (mode_q == MD_BOTH_DEC);
  // counting mode walks through the access states without a request
  assign acc_done  = is_count || mem_ack;

  always_comb begin
    ch_vec = '0;
    ch_vec[ch_q] = 1'b1;
  end

  assign take  = (state_q == ST_IDLE) && any_pend;
  assign rd_ch = (state_q == ST_IDLE) ? grant_ch : ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      mode_q  <= MD_DST_INC;
      size_q  <= '0;
      data_q  <= '0;
      tc_q    <= '0;
      err_q   <= '0;
    end else begin
      tc_q  <= '0;
      err_q <= err_q & ~err_clr;
      unique case (state_q)
        ST_IDLE: begin
          if (any_pend) begin
            if (!mode_word_ok(rd_mode)) begin
              err_q[grant_ch] <= 1'b1;
            end else if (rd_cnt != '0) begin
              ch_q    <= grant_ch;
              src_q   <= rd_src;
              dst_q   <= rd_dst;
              cnt_q   <= rd_cnt;
              mode_q  <= xfer_mode_e'(rd_mode[4:2]);
              size_q  <= rd_mode[1:0];
              state_q <= ST_SETUP;
            end
          end
        end
        ST_SETUP: state_q <= ST_READ;
        ST_READ: begin
          if (acc_done) begin
            if (!is_count) data_q <= mem_rdata;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (acc_done) state_q <= ST_STEP_A;
        end
        ST_STEP_A: state_q <= two_steps ? ST_STEP_B : ST_DONE;
        ST_STEP_B: state_q <= ST_DONE;
        ST_DONE: begin
          if (cnt_q == CNT_W'(1)) tc_q <= ch_vec;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Post-transfer address and count updates
  always_comb begin
    upd_ch     = ch_q;
    upd_src_we = 1'b0;
    upd_dst_we = 1'b0;
    upd_cnt_we = (state_q == ST_DONE);
    upd_src    = src_q;
    upd_dst    = dst_q;
    upd_cnt    = cnt_q - CNT_W'(1);
    if (state_q == ST_STEP_A) begin
      unique case (mode_q)
        MD_DST_INC: begin upd_dst_we = 1'b1; upd_dst = dst_q + step; end
        MD_DST_DEC: begin upd_dst_we = 1'b1; upd_dst = dst_q - step; end
        MD_SRC_INC, MD_BOTH_INC: begin upd_src_we = 1'b1; upd_src = src_q + step; end
        MD_SRC_DEC, MD_BOTH_DEC: begin upd_src_we = 1'b1; upd_src = src_q - step; end
        MD_COUNT:   begin upd_src_we = 1'b1; upd_src = src_q + ADDR_W'(1); end
        default: ;
      endcase
    end
    if (state_q == ST_STEP_B) begin
      upd_dst_we = 1'b1;
      upd_dst    = (mode_q == MD_BOTH_DEC) ? (dst_q - step) : (dst_q + step);
    end
  end

  assign mem_req   = ((state_q == ST_READ) || (state_q == ST_WRITE)) && !is_count;
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? dst_q : src_q;
  assign mem_size  = size_q;
  assign mem_wdata = data_q;
  assign busy      = (state_q != ST_IDLE);
  assign tc_irq    = tc_q;
  assign err_flag  = err_q;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] trig,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [NUM_CH-1:0] tc_irq,
  output logic [NUM_CH-1:0] err_flag,
  output logic              busy
);
  import dma_xfer_pkg::*;

  logic              any_pend;
  logic [CH_W-1:0]   grant_ch;
  logic              take;
  logic [CH_W-1:0]   rd_ch;
  logic [ADDR_W-1:0] rd_src;
  logic [ADDR_W-1:0] rd_dst;
  logic [CNT_W-1:0]  rd_cnt;
  logic [4:0]        rd_mode;
  logic [CH_W-1:0]   upd_ch;
  logic              upd_src_we;
  logic              upd_dst_we;
  logic              upd_cnt_we;
  logic [ADDR_W-1:0] upd_src;
  logic [ADDR_W-1:0] upd_dst;
  logic [CNT_W-1:0]  upd_cnt;
  logic [NUM_CH-1:0] err_clr;

  // Rewriting a channel's mode word clears its error flag
  always_comb begin
    err_clr = '0;
    if (cfg_we && (cfg_sel == SEL_MODE)) err_clr[cfg_ch] = 1'b1;
  end

  dma_prio_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) arb_i (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .take     (take),
    .take_ch  (grant_ch),
    .any_pend (any_pend),
    .grant_ch (grant_ch)
  );

  dma_chan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_W(CH_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_ch     (cfg_ch),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .upd_ch     (upd_ch),
    .upd_src_we (upd_src_we),
    .upd_dst_we (upd_dst_we),
    .upd_cnt_we (upd_cnt_we),
    .upd_src    (upd_src),
    .upd_dst    (upd_dst),
    .upd_cnt    (upd_cnt),
    .rd_ch      (rd_ch),
    .rd_src     (rd_src),
    .rd_dst     (rd_dst),
    .rd_cnt     (rd_cnt),
    .rd_mode    (rd_mode)
  );

  dma_xfer_seq #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .CH_W(CH_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .any_pend   (any_pend),
    .grant_ch   (grant_ch),
    .take       (take),
    .rd_ch      (rd_ch),
    .rd_src     (rd_src),
    .rd_dst     (rd_dst),
    .rd_cnt     (rd_cnt),
    .rd_mode    (rd_mode),
    .upd_ch     (upd_ch),
    .upd_src_we (upd_src_we),
    .upd_dst_we (upd_dst_we),
    .upd_cnt_we (upd_cnt_we),
    .upd_src    (upd_src),
    .upd_dst    (upd_dst),
    .upd_cnt    (upd_cnt),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .err_clr    (err_clr),
    .tc_irq     (tc_irq),
    .err_flag   (err_flag),
    .busy       (busy)
  );

endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NUM_CH-1:0] tc_irq,
  input logic [NUM_CH-1:0] err_flag
);

  logic [7:0] run_q;
  logic [7:0] stall_q;

  // Length of the current busy run and the number of wait cycles inside it
  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      run_q   <= '0;
      stall_q <= '0;
    end else begin
      if (run_q != 8'hFF) run_q <= run_q + 8'd1;
      if (mem_req && !mem_ack && stall_q != 8'hFF) stall_q <= stall_q + 8'd1;
    end
  end

  assert_req_inside_busy_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_hold_during_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_irq_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (|tc_irq) |=> (tc_irq == '0));

  assert_irq_one_channel_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tc_irq));

  assert_irq_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (|tc_irq) |-> (!busy && $past(busy)));

  assert_state_count_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && run_q != 8'd0) |-> ((run_q - stall_q == 8'd5) || (run_q - stall_q == 8'd6)));

  assert_refusal_no_transfer_R9: assert property (@(posedge clk) disable iff (rst)
    (|(err_flag & ~$past(err_flag))) |-> !busy);

endmodule

bind dma_xfer_engine dma_xfer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .tc_irq   (tc_irq),
  .err_flag (err_flag)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb_top;

  localparam int NUM_CH = 8;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam int CH_W   = 3;
  localparam logic [31:0] RD_OFS = 32'h1000_0007;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] trig = '0;
  logic              cfg_we = 1'b0;
  logic [CH_W-1:0]   cfg_ch = '0;
  logic [1:0]        cfg_sel = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              mem_req;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        mem_size;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_ack;
  logic [NUM_CH-1:0] tc_irq;
  logic [NUM_CH-1:0] err_flag;
  logic              busy;

  always #2 clk = ~clk;

  dma_xfer_engine #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst(rst), .trig(trig), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tc_irq(tc_irq), .err_flag(err_flag), .busy(busy)
  );

  // Memory model: read data is an arithmetic function of the address; ack after wait_cfg wait cycles
  int unsigned wait_cfg = 0;
  int unsigned wcnt = 0;
  assign mem_rdata = mem_addr * 32'd3 + RD_OFS;
  assign mem_ack   = mem_req && (wcnt >= wait_cfg);
  always @(posedge clk) begin
    if (mem_req && !mem_ack) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
  end

  // Monitor, sampled away from the active edge
  int unsigned busy_run, n_rd, n_wr, irq_cycles;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic [1:0]  rd_size;
  logic [31:0] rd_hist [8];
  logic [NUM_CH-1:0] irq_log;

  always @(negedge clk) begin
    if (busy) busy_run++;
    if (mem_req && mem_ack && !mem_we) begin
      if (n_rd < 8) rd_hist[n_rd] = mem_addr;
      rd_addr = mem_addr;
      rd_size = mem_size;
      n_rd++;
    end
    if (mem_req && mem_ack && mem_we) begin
      wr_addr = mem_addr;
      wr_data = mem_wdata;
      n_wr++;
    end
    if (|tc_irq) begin
      irq_log |= tc_irq;
      irq_cycles++;
    end
  end

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    busy_run = 0; n_rd = 0; n_wr = 0; irq_cycles = 0; irq_log = '0;
    rd_addr = '0; wr_addr = '0; wr_data = '0; rd_size = '0;
  endtask

  task automatic wr_reg(input int ch, input int sel, input logic [31:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_sel = 2'(sel); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [4:0] m);
    wr_reg(ch, 0, s);
    wr_reg(ch, 1, d);
    wr_reg(ch, 2, c);
    wr_reg(ch, 3, {27'd0, m});
  endtask

  task automatic fire(input logic [NUM_CH-1:0] v);
    @(negedge clk);
    clear_logs();
    trig = v;
    @(negedge clk);
    trig = '0;
    repeat (28) @(negedge clk);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] a, input int dir, input int sz);
    logic [31:0] st;
    st = 32'd1 << sz;
    if (dir > 0) return a + st;
    if (dir < 0) return a - st;
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !mem_req && tc_irq == '0 && err_flag == '0, "R1 reset outputs",
        {busy, mem_req, tc_irq, err_flag}, 32'd0);
    fire(8'h01);
    chk(busy_run == 0 && n_rd == 0, "R1 reset count is zero", busy_run, 0);

    // Sweep every channel, data-moving mode and legal size
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int md = 0; md < 7; md++) begin
        for (int sz = 0; sz < 3; sz++) begin
          logic [31:0] s0, d0, s1, d1;
          int ds, dd, expb;
          s0 = 32'h0001_0000 + 32'(ch) * 32'h1000 + 32'(md) * 32'h40 + 32'(sz) * 32'h8;
          d0 = 32'h0080_0000 + 32'(ch) * 32'h1000 + 32'(md) * 32'h40 + 32'(sz) * 32'h8;
          ds = (md == 2 || md == 4) ? 1 : (md == 3 || md == 5) ? -1 : 0;
          dd = (md == 0 || md == 4) ? 1 : (md == 1 || md == 5) ? -1 : 0;
          expb = (md == 4 || md == 5) ? 6 : 5;
          s1 = nxt(s0, ds, sz);
          d1 = nxt(d0, dd, sz);
          setup_ch(ch, s0, d0, 32'd2, 5'(md * 4 + sz));
          fire(8'(1 << ch));
          chk(n_rd == 1 && rd_addr == s0, "R2 read address", rd_addr, s0);
          chk(rd_size == 2'(sz), "R2 size code", 32'(rd_size), 32'(sz));
          chk(n_wr == 1 && wr_addr == d0, "R2 write address", wr_addr, d0);
          chk(wr_data == s0 * 32'd3 + RD_OFS, "R2 write data", wr_data, s0 * 32'd3 + RD_OFS);
          chk(busy_run == 32'(expb), "R6 state count", busy_run, 32'(expb));
          chk(irq_log == '0, "R4 no irq before zero", 32'(irq_log), 0);
          fire(8'(1 << ch));
          if (md == 6) begin
            chk(rd_addr == s0 && wr_addr == d0, "R11 fixed addresses", wr_addr, d0);
          end else begin
            chk(rd_addr == s1, "R3 source post-step", rd_addr, s1);
            chk(wr_addr == d1, "R3 destination post-step", wr_addr, d1);
          end
          chk(irq_log == 8'(1 << ch) && irq_cycles == 1, "R4 terminal pulse",
              {irq_cycles[15:0], 8'h0, irq_log}, {16'd1, 8'h0, 8'(1 << ch)});
        end
      end
    end

    // R5: counting mode on every channel
    for (int ch = 0; ch < NUM_CH; ch++) begin
      setup_ch(ch, 32'h40 + 32'(ch), 32'h900, 32'd3, 5'b11100);
      fire(8'(1 << ch));
      chk(n_rd == 0 && n_wr == 0, "R5 no access", n_rd + n_wr, 0);
      chk(busy_run == 5, "R6 counting state count", busy_run, 5);
      fire(8'(1 << ch));
      wr_reg(ch, 3, 32'b00000);
      fire(8'(1 << ch));
      chk(rd_addr == 32'h42 + 32'(ch), "R5 source advanced by one", rd_addr, 32'h42 + 32'(ch));
      chk(irq_log == 8'(1 << ch), "R5 count reached zero", 32'(irq_log), 32'(1 << ch));
    end

    // R7: wait cycles stretch the transfer
    for (int w = 1; w < 4; w++) begin
      wait_cfg = w;
      setup_ch(1, 32'h3000, 32'h7000, 32'd5, 5'b10010);
      fire(8'h02);
      chk(busy_run == 32'(6 + 2 * w), "R7 stretched count", busy_run, 32'(6 + 2 * w));
      chk(rd_addr == 32'h3000 && wr_addr == 32'h7000, "R7 addresses under wait", wr_addr, 32'h7000);
      chk(wr_data == 32'h3000 * 32'd3 + RD_OFS, "R7 data under wait", wr_data, 32'h3000 * 32'd3 + RD_OFS);
    end
    wait_cfg = 0;

    // R8: lowest index first when triggered together
    setup_ch(2, 32'h200, 32'hA00, 32'd1, 5'b00000);
    setup_ch(5, 32'h500, 32'hD00, 32'd1, 5'b00000);
    fire(8'h24);
    chk(n_rd == 2 && rd_hist[0] == 32'h200, "R8 first served", rd_hist[0], 32'h200);
    chk(rd_hist[1] == 32'h500, "R8 second served", rd_hist[1], 32'h500);
    chk(irq_log == 8'h24, "R8 both terminal", 32'(irq_log), 32'h24);

    // R8: trigger during a busy transfer is held
    setup_ch(6, 32'h600, 32'hE00, 32'd1, 5'b00000);
    setup_ch(1, 32'h100, 32'hB00, 32'd1, 5'b00000);
    @(negedge clk);
    clear_logs();
    trig = 8'h40;
    @(negedge clk);
    trig = '0;
    @(negedge clk);
    trig = 8'h02;
    @(negedge clk);
    trig = '0;
    repeat (28) @(negedge clk);
    chk(n_rd == 2 && rd_hist[0] == 32'h600 && rd_hist[1] == 32'h100, "R8 held trigger",
        rd_hist[1], 32'h100);

    // R9: reserved size and counting with nonzero size
    setup_ch(3, 32'h333, 32'hC33, 32'd1, 5'b01011);
    fire(8'h08);
    chk(busy_run == 0 && n_rd == 0, "R9 reserved size dropped", busy_run, 0);
    chk(err_flag == 8'h08, "R9 flag set", 32'(err_flag), 32'h08);
    setup_ch(4, 32'h444, 32'hC44, 32'd1, 5'b11101);
    fire(8'h10);
    chk(busy_run == 0 && err_flag == 8'h18, "R9 counting size refused", 32'(err_flag), 32'h18);
    wr_reg(3, 3, 32'b01000);
    @(negedge clk);
    chk(err_flag == 8'h10, "R9 flag cleared by mode write", 32'(err_flag), 32'h10);
    fire(8'h08);
    chk(rd_addr == 32'h333 && irq_log == 8'h08, "R9 registers unchanged", rd_addr, 32'h333);
    wr_reg(4, 3, 32'b00000);

    // R10: zero count
    setup_ch(7, 32'h777, 32'hF77, 32'd0, 5'b00000);
    fire(8'h80);
    chk(busy_run == 0 && n_rd == 0 && irq_log == '0 && err_flag == '0, "R10 zero count ignored",
        busy_run, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule